// File: doc/BRIEF.md
# Global Exclusive Access Monitor

This block sits in front of a small shared memory and arbitrates exclusive read/write pairs issued by several requesters, each identified by a transaction ID. An exclusive read claims a monitor entry recording the requester's ID and the byte span it read. A later exclusive write from that ID succeeds only if the claim is still intact. A successful write returns EXOKAY and lands in memory. A failed one returns OKAY and leaves memory untouched. Any write that actually changes memory, whether exclusive or normal, cancels every claim whose span it touches. This lets software build semaphores without locking the bus.

Requests arrive on one simplified port with a valid/ready pair. Each request carries a write flag, an exclusive flag, an ID, a byte address, a byte count and write data. Requests are taken one per cycle. Each is answered on a response port exactly one cycle after acceptance, with read data and a one-bit response code. The monitor check, the claim updates and the memory write all happen in the single accepting cycle, so no other request can slip between them.

Top module: `excl_monitor`

## Requirements
- R1: An accepted exclusive read (reqWrite=0, reqExcl=1) claims a monitor entry for its ID over bytes [reqAddr, reqAddr+reqLen] and responds with rspExOkay=1 and the addressed bytes.
- R2: An exclusive write whose whole byte range lies inside a live claim of the same ID responds rspExOkay=1, writes memory and releases that claim, so an immediate retry gets rspExOkay=0.
- R3: An exclusive write with no covering live claim for its ID responds rspExOkay=0 and leaves memory unchanged.
- R4: A successful exclusive write cancels the overlapping claims of every other ID, whose later exclusive writes then get rspExOkay=0.
- R5: A normal write (reqWrite=1, reqExcl=0) always updates memory, responds rspExOkay=0 and cancels every claim it overlaps.
- R6: Cancellation uses a byte-range overlap test: a write touching any claimed byte cancels the claim, and a write next to the claim but not on it leaves the claim intact.
- R7: Reads never cancel any claim, and a normal read responds rspExOkay=0 with the addressed bytes.
- R8: An ID holds at most one claim at a time. A new exclusive read from an ID that already holds a claim replaces it, so the old range's exclusive write fails and the new one can succeed.
- R9: With NUM_MON entries, NUM_MON distinct IDs can hold claims on distinct addresses at once, and all of their exclusive writes succeed.
- R10: If an exclusive read comes from an ID with no claim while all entries are live, the entry at a replacement pointer is reused. The pointer starts at entry 0 after reset and advances by one, wrapping, on each such replacement. Otherwise the lowest free entry is used.
- R11: reqReady is 0 in reset and 1 from the first clock after it. rspValid is 1 exactly in the cycle after an accepted request.
- R12: reqLen encodes byte count minus one. Byte k of the access sits in data lane k (bits 8k+7:8k) at address reqAddr+k. Bytes past the top of memory are not written and read as zero. Unused read lanes and the data of write responses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block accepts a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqExcl | input | 1 | 1 = exclusive access |
| reqId | input | ID_W | Transaction ID |
| reqAddr | input | ADDR_W | Start byte address |
| reqLen | input | $clog2(DATA_W/8) | Byte count minus one |
| reqWdata | input | DATA_W | Write data, byte k in lane k |
| rspValid | output | 1 | Response present |
| rspData | output | DATA_W | Read data, zero for writes |
| rspExOkay | output | 1 | 1 = EXOKAY, 0 = OKAY |

## Verification
The bench uses the defaults: four monitor entries, a 64-byte memory and a 32-bit data path. Random traffic draws from six IDs over sixteen addresses with 1 to 4 byte spans. With more IDs than entries, the table fills and replacement is exercised often. The narrow address window makes partial overlaps and cross-ID cancellation common. Directed sequences cover the two-requester race, same-ID replacement, adjacent-but-disjoint writes and an access running off the top of memory.

// File: rtl/exmon_pkg.sv
package exmon_pkg;

  // Per-request strobes from control to datapath
  typedef struct packed {
    logic accept;   // request taken this cycle
    logic isRead;   // accepted request is a read
    logic memWe;    // memory is written this cycle
    logic exOkay;   // response code to return
  } strobe_t;

endpackage

// File: rtl/exmon_ctrl.sv
module exmon_ctrl
  import exmon_pkg::*;
#(
  parameter int NUM_MON = 4,
  parameter int ID_W    = 3,
  parameter int ADDR_W  = 6,
  parameter int LEN_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqExcl,
  input  logic [ID_W-1:0]   reqId,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              reqReady,
  output strobe_t           strobes
);

  localparam int PTR_W = (NUM_MON > 1) ? $clog2(NUM_MON) : 1;
  localparam int END_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_MON - 1);

  logic [NUM_MON-1:0] monValid;
  logic [ID_W-1:0]    monId [NUM_MON];
  logic [END_W-1:0]   monLo [NUM_MON];
  logic [END_W-1:0]   monHi [NUM_MON];
  logic [PTR_W-1:0]   victimPtr;
  logic               readyQ;

  logic [END_W-1:0]   reqLo, reqHi;
  logic [NUM_MON-1:0] idHit, spanHit, overlap;
  logic               haveSame, haveFree, anySpan, accept, rdExcl;
  logic [PTR_W-1:0]   sameIdx, freeIdx, allocIdx;

  assign reqLo = END_W'(reqAddr);
  assign reqHi = reqLo + END_W'(reqLen);

  // Per-entry comparators
  for (genvar i = 0; i < NUM_MON; i++) begin : g_cmp
    assign idHit[i]   = monValid[i] && (monId[i] == reqId);
    assign spanHit[i] = idHit[i] && (reqLo >= monLo[i]) && (reqHi <= monHi[i]);
    assign overlap[i] = monValid[i] && (reqLo <= monHi[i]) && (monLo[i] <= reqHi);
  end

  // Entry selection for an exclusive read: own entry, else lowest free, else victim
  always_comb begin
    haveSame = 1'b0;
    haveFree = 1'b0;
    sameIdx  = '0;
    freeIdx  = '0;
    for (int i = NUM_MON - 1; i >= 0; i--) begin
      if (idHit[i]) begin
        haveSame = 1'b1;
        sameIdx  = PTR_W'(i);
      end
      if (!monValid[i]) begin
        haveFree = 1'b1;
        freeIdx  = PTR_W'(i);
      end
    end
    allocIdx = haveSame ? sameIdx : (haveFree ? freeIdx : victimPtr);
  end

  assign anySpan  = |spanHit;
  assign accept   = reqValid && readyQ;
  assign rdExcl   = accept && !reqWrite && reqExcl;
  assign reqReady = readyQ;

  always_comb begin
    strobes.accept = accept;
    strobes.isRead = accept && !reqWrite;
    strobes.memWe  = accept && reqWrite && (!reqExcl || anySpan);
    strobes.exOkay = accept && reqExcl && (!reqWrite || anySpan);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ    <= 1'b0;
      victimPtr <= '0;
      monValid  <= '0;
      for (int i = 0; i < NUM_MON; i++) begin
        monId[i] <= '0;
        monLo[i] <= '0;
        monHi[i] <= '0;
      end
    end else begin
      readyQ <= 1'b1;
      if (strobes.memWe) begin
        for (int i = 0; i < NUM_MON; i++) begin
          if (overlap[i]) monValid[i] <= 1'b0;
        end
      end
      if (rdExcl) begin
        monValid[allocIdx] <= 1'b1;
        monId[allocIdx]    <= reqId;
        monLo[allocIdx]    <= reqLo;
        monHi[allocIdx]    <= reqHi;
        if (!haveSame && !haveFree)
          victimPtr <= (victimPtr == LAST_IDX) ? '0 : victimPtr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/exmon_dp.sv
module exmon_dp
  import exmon_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspExOkay
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int BYTES = DATA_W / 8;
  localparam int END_W = ADDR_W + 1;

  logic [7:0]        mem [DEPTH];
  logic [DATA_W-1:0] rdData;
  logic [END_W-1:0]  laneAddr [BYTES];
  logic [BYTES-1:0]  laneOn;

  // Lane k maps to address reqAddr+k; lanes past the count or past the top are off
  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    assign laneAddr[k] = END_W'(reqAddr) + END_W'(k);
    assign laneOn[k]   = (LEN_W'(k) <= reqLen) && !laneAddr[k][ADDR_W];
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < BYTES; k++) begin
      if (laneOn[k]) rdData[8*k +: 8] = mem[laneAddr[k][ADDR_W-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (strobes.memWe) begin
      for (int k = 0; k < BYTES; k++) begin
        if (laneOn[k]) mem[laneAddr[k][ADDR_W-1:0]] <= reqWdata[8*k +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspExOkay <= 1'b0;
      rspData   <= '0;
    end else begin
      rspValid  <= strobes.accept;
      rspExOkay <= strobes.exOkay;
      if (strobes.accept) rspData <= strobes.isRead ? rdData : '0;
    end
  end

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import exmon_pkg::*;
#(
  parameter int NUM_MON = 4,
  parameter int ID_W    = 3,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic              reqExcl,
  input  logic [ID_W-1:0]   reqId,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspExOkay
);

  strobe_t strobes;

  exmon_ctrl #(
    .NUM_MON(NUM_MON), .ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqExcl(reqExcl), .reqId(reqId), .reqAddr(reqAddr), .reqLen(reqLen),
    .reqReady(reqReady), .strobes(strobes)
  );

  exmon_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqWdata(reqWdata), .rspValid(rspValid),
    .rspData(rspData), .rspExOkay(rspExOkay)
  );

endmodule

// File: rtl/exmon_chk.sv
module exmon_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic reqWrite,
  input logic reqExcl,
  input logic memWe,
  input logic rspValid,
  input logic rspExOkay
);

  // R11
  accept_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

  // R11
  idle_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> !rspValid);

  // R5
  plain_write_okay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite && !reqExcl) |=> !rspExOkay);

  // R7
  read_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite) |=> (rspExOkay == $past(reqExcl)));

  // R2
  exwrite_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite && reqExcl) |=> (rspExOkay == $past(memWe)));

  // R3
  write_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (reqValid && reqReady && reqWrite));

endmodule

bind excl_monitor exmon_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqWrite(reqWrite), .reqExcl(reqExcl), .memWe(strobes.memWe),
  .rspValid(rspValid), .rspExOkay(rspExOkay)
);

// File: tb/excl_monitor_tb.sv
module excl_monitor_tb;

  localparam int NMON = 4;
  localparam int IDW  = 3;
  localparam int AW   = 6;
  localparam int DW   = 32;
  localparam int LW   = 2;
  localparam int DEP  = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqExcl = 1'b0;
  logic [IDW-1:0] reqId = '0;
  logic [AW-1:0]  reqAddr = '0;
  logic [LW-1:0]  reqLen = '0;
  logic [DW-1:0]  reqWdata = '0;
  logic reqReady, rspValid, rspExOkay;
  logic [DW-1:0] rspData;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;
  bit lastEx;

  // Reference model state
  bit mV [NMON];
  int mId [NMON], mLo [NMON], mHi [NMON];
  int mPtr;
  logic [7:0] mMem [DEP];

  always #5 clk = ~clk;

  excl_monitor #(.NUM_MON(NMON), .ID_W(IDW), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqExcl(reqExcl), .reqId(reqId), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqWdata(reqWdata), .rspValid(rspValid),
    .rspData(rspData), .rspExOkay(rspExOkay)
  );

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Model one request; returns expected code and data
  function automatic void modelStep(input bit w, input bit e, input int id, input int a,
                                    input int l, input logic [DW-1:0] d,
                                    output bit expEx, output logic [DW-1:0] expData);
    int lo = a;
    int hi = a + l;
    int idx;
    bit ok;
    expData = '0;
    expEx = 1'b0;
    if (!w) begin
      for (int k = 0; k <= l; k++)
        if (a + k < DEP) expData[8*k +: 8] = mMem[a + k];
      if (e) begin
        idx = -1;
        for (int i = 0; i < NMON; i++) if (idx < 0 && mV[i] && mId[i] == id) idx = i;
        for (int i = 0; i < NMON; i++) if (idx < 0 && !mV[i]) idx = i;
        if (idx < 0) begin
          idx = mPtr;
          mPtr = (mPtr + 1) % NMON;
        end
        mV[idx] = 1'b1; mId[idx] = id; mLo[idx] = lo; mHi[idx] = hi;
        expEx = 1'b1;
      end
    end else begin
      ok = !e;
      if (e)
        for (int i = 0; i < NMON; i++)
          if (mV[i] && mId[i] == id && lo >= mLo[i] && hi <= mHi[i]) ok = 1'b1;
      expEx = e && ok;
      if (ok) begin
        for (int k = 0; k <= l; k++)
          if (a + k < DEP) mMem[a + k] = d[8*k +: 8];
        for (int i = 0; i < NMON; i++)
          if (mV[i] && lo <= mHi[i] && mLo[i] <= hi) mV[i] = 1'b0;
      end
    end
  endfunction

  // Issue one request at a negedge and check the response at the next negedge
  task automatic xfer(input bit w, input bit e, input int id, input int a, input int l,
                      input logic [DW-1:0] d, input string tag);
    bit expEx;
    logic [DW-1:0] expData;
    modelStep(w, e, id, a, l, d, expEx, expData);
    reqValid = 1'b1; reqWrite = w; reqExcl = e;
    reqId = IDW'(id); reqAddr = AW'(a); reqLen = LW'(l); reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    check(rspValid === 1'b1, {tag, " R11 rspValid"}, DW'(rspValid), 1);
    check(rspExOkay === expEx, {tag, " code"}, DW'(rspExOkay), DW'(expEx));
    check(rspData === expData, {tag, " data"}, rspData, expData);
    lastEx = rspExOkay;
  endtask

  task automatic expectCode(input bit exp, input string tag);
    check(lastEx == exp, tag, DW'(lastEx), DW'(exp));
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    bit w, e;
    void'($urandom(32'd1234));
    for (int i = 0; i < NMON; i++) begin mV[i] = 0; mId[i] = 0; mLo[i] = 0; mHi[i] = 0; end
    for (int i = 0; i < DEP; i++) mMem[i] = '0;
    mPtr = 0;

    repeat (3) @(negedge clk);
    check(reqReady === 1'b0, "R11 ready low in reset", DW'(reqReady), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady === 1'b1, "R11 ready after reset", DW'(reqReady), 1);
    check(rspValid === 1'b0, "R11 no response after reset", DW'(rspValid), 0);
    @(negedge clk);
    check(rspValid === 1'b0, "R11 idle no response", DW'(rspValid), 0);

    // R1 / R2: basic pair, then retry without a new claim
    xfer(0, 1, 1, 0, 3, '0, "R1 exrd");
    expectCode(1, "R1 exrd EXOKAY");
    xfer(1, 1, 1, 0, 3, 32'h11223344, "R2 exwr");
    expectCode(1, "R2 exwr EXOKAY");
    xfer(0, 0, 5, 0, 3, '0, "R2 readback");
    xfer(1, 1, 1, 0, 3, 32'hDEADBEEF, "R2 retry");
    expectCode(0, "R2 retry OKAY after release");
    xfer(0, 0, 5, 0, 3, '0, "R3 mem unchanged");

    // R4: two requesters race
    xfer(0, 1, 1, 8, 3, '0, "R4 id1 exrd");
    xfer(0, 1, 2, 8, 3, '0, "R4 id2 exrd");
    xfer(1, 1, 2, 8, 3, 32'hA5A5A5A5, "R4 id2 exwr");
    expectCode(1, "R4 id2 wins");
    xfer(1, 1, 1, 8, 3, 32'h5A5A5A5A, "R4 id1 exwr");
    expectCode(0, "R4 id1 loses");

    // R5: normal write cancels
    xfer(0, 1, 1, 16, 3, '0, "R5 exrd");
    xfer(1, 0, 3, 16, 3, 32'h01020304, "R5 plain wr");
    expectCode(0, "R5 plain write OKAY");
    xfer(1, 1, 1, 16, 3, 32'hFFFFFFFF, "R5 exwr");
    expectCode(0, "R5 exwr fails");

    // R6: partial overlap cancels, adjacent does not
    xfer(0, 1, 1, 20, 3, '0, "R6 exrd a");
    xfer(1, 0, 4, 23, 0, 32'h77, "R6 one-byte overlap");
    xfer(1, 1, 1, 20, 3, 32'h12345678, "R6 exwr a");
    expectCode(0, "R6 overlap cancels");
    xfer(0, 1, 2, 24, 3, '0, "R6 exrd b");
    xfer(1, 0, 4, 28, 3, 32'h99999999, "R6 adjacent wr");
    xfer(1, 1, 2, 24, 3, 32'h87654321, "R6 exwr b");
    expectCode(1, "R6 adjacent keeps claim");

    // R7: reads never cancel
    xfer(0, 1, 4, 32, 3, '0, "R7 exrd id4");
    xfer(0, 0, 5, 32, 3, '0, "R7 plain read");
    expectCode(0, "R7 plain read OKAY");
    xfer(0, 1, 5, 32, 1, '0, "R7 exrd id5");
    xfer(1, 1, 4, 32, 3, 32'hCAFEF00D, "R7 exwr id4");
    expectCode(1, "R7 claim survived reads");

    // R8: one claim per ID
    xfer(0, 1, 1, 40, 1, '0, "R8 exrd old");
    xfer(0, 1, 1, 44, 1, '0, "R8 exrd new");
    xfer(1, 1, 1, 40, 1, 32'h1111, "R8 exwr old");
    expectCode(0, "R8 old claim replaced");
    xfer(1, 1, 1, 44, 1, 32'h2222, "R8 exwr new");
    expectCode(1, "R8 new claim holds");

    // R9: all entries live at once
    for (int i = 0; i < NMON; i++) xfer(0, 1, i, 48 + 2 * i, 1, '0, "R9 exrd");
    for (int i = 0; i < NMON; i++) begin
      xfer(1, 1, i, 48 + 2 * i, 1, DW'(32'h100 + i), "R9 exwr");
      expectCode(1, "R9 all succeed");
    end

    // R10: replacement when full
    for (int i = 0; i < NMON; i++) xfer(0, 1, i, 4 * i, 1, '0, "R10 fill");
    xfer(0, 1, 5, 60, 1, '0, "R10 evict");
    xfer(1, 1, 0, 0, 1, 32'h3333, "R10 evicted id");
    expectCode(0, "R10 entry 0 replaced");
    xfer(1, 1, 1, 4, 1, 32'h4444, "R10 kept id");
    expectCode(1, "R10 entry 1 kept");

    // R12: top-of-memory boundary
    xfer(1, 0, 3, 62, 3, 32'hAABBCCDD, "R12 wr past top");
    xfer(0, 0, 3, 62, 3, '0, "R12 rd past top");
    check(lastEx == 0, "R12 read OKAY", DW'(lastEx), 0);
    check(rspData === 32'h0000CCDD, "R12 lanes", rspData, 32'h0000CCDD);

    // Random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom % 100;
      w = (r >= 40 && r < 85);
      e = (r < 40) || (r >= 40 && r < 70);
      xfer(w, e, $urandom % 6, $urandom % 16, $urandom % 4, $urandom, "R1-mix random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule